// File: doc/BRIEF.md
# Power-Loss Restore Controller

This block decides, each time mains power comes back after an outage, whether the system is asked to power up. A small control register holds a two-bit restore policy and a resume-enable bit. The policy can keep the system off, turn it on, or bring it back to whatever state it was in before the outage. The resume-enable bit gates every request. To support the last of these policies, the block keeps a copy of the system power state in logic meant for the always-on domain. That copy follows the live state only while AC power is good.

When the AC-good input rises, the block checks the policy, the enable bit and the remembered state. If they call for power-up, it drives a power-on request high for a fixed number of cycles, set by a parameter. If AC-good drops while the request is still high, the request is withdrawn. The register is reached through a plain write strobe and a read strobe. A read captures the register into a read-data output one cycle later.

Top module: `pwr_restore_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `pwr_on_req` is low and the remembered power state is "off".
- R2: Register layout: bit 7 is the resume enable (1 = enabled), bits 6:5 are the restore policy, and bits 4:0 always read as zero whatever is written to them.
- R3: A write with `reg_wr` high loads the register at the clock edge. With `reg_rd` high, `reg_rdata` shows the register contents from the following cycle and holds that value until the next read.
- R4: Policy 00 (stay off) never raises `pwr_on_req`.
- R5: With policy 01 (turn on) and resume enabled, the first cycle in which `ac_good` is sampled high after being low starts a request. `pwr_on_req` is then high for exactly `PULSE_LEN` cycles, starting on the cycle after that one.
- R6: With policy 10 (restore previous) and resume enabled, a request of `PULSE_LEN` cycles is issued only if `sys_on` was high in the last cycle in which `ac_good` was high before the outage.
- R7: Policy 11 is reserved and behaves as stay off: no request is issued.
- R8: With the resume enable at 0, no request is issued for any policy.
- R9: The remembered power state changes only in cycles where `ac_good` is high. Changes on `sys_on` during an outage have no effect on the next restore decision.
- R10: If `ac_good` falls while a request is running, `pwr_on_req` is low from the next cycle on.
- R11: Each rise of `ac_good` gives at most one request. `pwr_on_req` stays low while `ac_good` stays high after the request ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ac_good | input | 1 | Mains power good, synchronous to clk |
| sys_on | input | 1 | Current system power state (1 = on) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Captured register contents |
| pwr_on_req | output | 1 | Power-on request pulse |

## Verification
Outages are driven under every policy and both enable values, starting from both the on and the off state. This separates the three policies from one another and shows that the enable gates each of them. During outages `sys_on` is toggled at random, which checks that only the state before the outage counts. Register writes carry random values in the reserved bits, so the read-back shows that those bits are masked. Directed cases cover the reset state and a request cut short by a second outage.

// File: rtl/pwr_restore_pkg.sv
package pwr_restore_pkg;

  localparam int unsigned CFG_W      = 8;
  localparam int unsigned EN_BIT     = 7;
  localparam int unsigned POL_LSB    = 5;
  localparam int unsigned POL_W      = 2;

  typedef enum logic [POL_W-1:0] {
    POL_OFF  = 2'b00,
    POL_ON   = 2'b01,
    POL_PREV = 2'b10,
    POL_RSVD = 2'b11
  } restore_pol_e;

  typedef struct packed {
    logic         resume_en;
    restore_pol_e policy;
  } restore_cfg_t;

  function automatic logic [CFG_W-1:0] pack_cfg(input restore_cfg_t c);
    logic [CFG_W-1:0] v;
    v = '0;
    v[EN_BIT] = c.resume_en;
    v[POL_LSB +: POL_W] = c.policy;
    return v;
  endfunction

endpackage

// File: rtl/pr_cfg_reg.sv
module pr_cfg_reg
  import pwr_restore_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             rd,
  output logic [CFG_W-1:0] rdata,
  output restore_cfg_t     cfg
);

  restore_cfg_t     cfg_q, cfg_d;
  logic [CFG_W-1:0] rdata_q, rdata_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr) begin
      cfg_d.resume_en = wdata[EN_BIT];
      cfg_d.policy    = restore_pol_e'(wdata[POL_LSB +: POL_W]);
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd) rdata_d = pack_cfg(cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '{resume_en: 1'b0, policy: POL_OFF};
      rdata_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      rdata_q <= rdata_d;
    end
  end

  assign cfg   = cfg_q;
  assign rdata = rdata_q;

  // R3
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cfg_q.policy == $past(wdata[POL_LSB +: POL_W])) &&
           (cfg_q.resume_en == $past(wdata[EN_BIT])));

  // R2
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (rdata[POL_LSB-1:0] == '0));

endmodule

// File: rtl/pr_state_keep.sv
module pr_state_keep (
  input  logic clk,
  input  logic rst_n,
  input  logic ac_good,
  input  logic sys_on,
  output logic saved_on
);

  logic saved_q, saved_d;

  always_comb begin
    saved_d = saved_q;
    if (ac_good) saved_d = sys_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) saved_q <= 1'b0;
    else        saved_q <= saved_d;
  end

  assign saved_on = saved_q;

  // R9
  outage_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_good |=> (saved_on == $past(saved_on)));

endmodule

// File: rtl/pr_req_pulse.sv
module pr_req_pulse #(
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic abort,
  output logic req
);

  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (abort) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (fire) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign req = (cnt_q != '0);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL);

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !req);

endmodule

// File: rtl/pwr_restore_ctrl.sv
module pwr_restore_ctrl
  import pwr_restore_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ac_good,
  input  logic             sys_on,
  input  logic             reg_wr,
  input  logic [CFG_W-1:0] reg_wdata,
  input  logic             reg_rd,
  output logic [CFG_W-1:0] reg_rdata,
  output logic             pwr_on_req
);

  restore_cfg_t cfg;
  logic         saved_on;
  logic         ac_q, ac_d;
  logic         ac_rise;
  logic         pol_wants_on;
  logic         fire;

  pr_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .rd    (reg_rd),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  pr_state_keep u_keep (
    .clk      (clk),
    .rst_n    (rst_n),
    .ac_good  (ac_good),
    .sys_on   (sys_on),
    .saved_on (saved_on)
  );

  assign ac_d = ac_good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ac_q <= 1'b0;
    else        ac_q <= ac_d;
  end

  assign ac_rise = ac_good & ~ac_q;

  always_comb begin
    unique case (cfg.policy)
      POL_ON:   pol_wants_on = 1'b1;
      POL_PREV: pol_wants_on = saved_on;
      default:  pol_wants_on = 1'b0;
    endcase
  end

  assign fire = ac_rise & cfg.resume_en & pol_wants_on;

  pr_req_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .abort (~ac_good),
    .req   (pwr_on_req)
  );

  // R11
  req_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on_req) |-> $past(ac_good));

  // R8
  req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on_req) |-> $past(cfg.resume_en));

  // R4
  req_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on_req) |-> ($past(cfg.policy) == POL_ON) || ($past(cfg.policy) == POL_PREV));

endmodule

// File: tb/pwr_restore_ctrl_test.sv
module pwr_restore_ctrl_test;

  localparam int unsigned PLEN = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ac_good, sys_on, reg_wr, reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       pwr_on_req;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  pwr_restore_ctrl #(.PULSE_LEN(PLEN)) uut (
    .clk(clk), .rst_n(rst_n), .ac_good(ac_good), .sys_on(sys_on),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .pwr_on_req(pwr_on_req)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] w);
    return w & 8'hE0;
  endfunction

  function automatic bit exp_fire(input logic [7:0] c, input bit last_on);
    if (!c[7]) return 1'b0;
    case (c[6:5])
      2'b01:   return 1'b1;
      2'b10:   return last_on;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_tag(input logic [7:0] c);
    if (!c[7]) return "R8";
    case (c[6:5])
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6/R9";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_read(input logic [7:0] w);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    check("R2/R3 readback", reg_rdata, exp_read(w));
  endtask

  // raise ac_good on a negedge and measure the pulse that follows
  task automatic restore_and_measure(input string tag, input bit exp);
    int hi = 0;
    bit first;
    ac_good = 1'b1; sys_on = 1'b0;
    @(negedge clk); first = pwr_on_req;
    for (int i = 0; i < PLEN + 3; i++) begin
      if (pwr_on_req) hi++;
      @(negedge clk);
    end
    check({tag, " first cycle"}, first, exp);
    check({tag, " pulse length"}, hi, exp ? PLEN : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] cfgv;
    bit         last_on;
    void'($urandom(32'd1234));
    rst_n = 1'b0; ac_good = 1'b0; sys_on = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 req low", pwr_on_req, 0);
    check("R1 rdata", reg_rdata, 0);
    reg_rd = 1'b1; @(negedge clk); reg_rd = 1'b0;
    check("R1 cfg reads 0x00", reg_rdata, 0);
    // R1: default stay-off on first power-up
    restore_and_measure("R1 default", 1'b0);

    // R2: reserved bits masked
    write_read(8'hFF);
    write_read(8'h1F);

    // R1: remembered state starts off - restore-previous with sys_on never high
    // (ac_good high since above, sys_on low) then outage
    write_read(8'hC0);
    @(negedge clk); ac_good = 1'b0;
    repeat (3) @(negedge clk);
    restore_and_measure("R1/R6 saved off", 1'b0);

    // R10: abort a running request
    write_read(8'hA0);
    @(negedge clk); ac_good = 1'b0;
    repeat (2) @(negedge clk);
    ac_good = 1'b1;
    @(negedge clk);
    check("R10 started", pwr_on_req, 1);
    @(negedge clk); ac_good = 1'b0;
    @(negedge clk);
    check("R10 aborted", pwr_on_req, 0);
    repeat (PLEN) @(negedge clk);
    check("R10 stays low", pwr_on_req, 0);
    ac_good = 1'b1;
    repeat (PLEN + 3) @(negedge clk);

    // random trials over policies, enable and pre-outage state
    for (int t = 0; t < 80; t++) begin
      cfgv = 8'($urandom);
      write_read(cfgv);
      last_on = 1'($urandom);
      sys_on = last_on;
      repeat (1 + $urandom % 4) @(negedge clk);
      // R11: no request while power stays good
      check("R11 steady", pwr_on_req, 0);
      ac_good = 1'b0; sys_on = 1'b0;
      for (int k = 0; k < 2 + int'($urandom % 5); k++) begin
        @(negedge clk);
        sys_on = 1'($urandom);   // R9: ignored during outage
      end
      @(negedge clk);
      restore_and_measure(req_tag(cfgv), exp_fire(cfgv, last_on));
      check("R11 after pulse", pwr_on_req, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule